// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block is the timer unit of an embedded processor core. A shared time-base tick drives three timers. A programmable interval timer counts down from a loaded value and can reload itself. A fixed interval timer signals at a power-of-two period chosen by a control field. A watchdog moves through three stages and ends in a selectable reset request.

Software writes a control word, a write-one-to-clear status word and the interval reload value through a single-cycle write port. The block drives three interrupt request lines and three one-cycle reset request pulses for core, chip and system. The control word, the status word and the running interval count are always visible on outputs, so the surrounding core can read them.

The period fields select exponents built from parameters: `FIT_BASE_EXP + k*EXP_STEP` for the fixed timer and `WD_BASE_EXP + k*EXP_STEP` for the watchdog, where k is the 2-bit field value. With the defaults, the fixed timer periods are 2^9, 2^13, 2^17 and 2^21 ticks, and the watchdog periods are 2^17, 2^21, 2^25 and 2^29 ticks.

Top module: `emb_tmr_top`

## Requirements
- R1: After reset, the control word, the status word, the interval count, the shared time-base count, all three interrupt requests and all three reset pulses are zero.
- R2: `wr_sel` chooses the write target: 0 is the control word, 1 is the status word, 2 is the interval reload, and 3 writes nothing. A control write keeps only bits 31:22, and bits 21:0 read as zero. The control fields are: watchdog period [31:30], watchdog reset kind [29:28], watchdog interrupt enable 27, interval interrupt enable 26, fixed period [25:24], fixed interrupt enable 23, auto-reload 22.
- R3: A status write clears each of bits 31:26 that is written as 1 and leaves bits written as 0 unchanged. Status bits 25:0 always read as zero. Writing 1 to bit 31 also drops `irq_pit`, while status bit 27 is unaffected unless it is also written as 1.
- R4: A write to the interval reload loads both the reload value and the count. On each tick, the count decrements only when the reload value is greater than 1, interval interrupt enable is set, and the count is nonzero. Otherwise the count holds.
- R5: A tick that finds a running count of 1 is an expiry. An expiry sets status bit 27 and raises `irq_pit`. The count then takes the reload value if auto-reload is set, and otherwise becomes 0 and stops.
- R6: A fixed-timer period ends on a tick at which the low E bits of the time base are all ones, where E = FIT_BASE_EXP + EXP_STEP*ctrl[25:24]. The time base starts at 0 and adds 1 on each tick. A period end sets status bit 26 and raises `irq_fit` if ctrl[23] is set. Writing 1 to status bit 26 drops `irq_fit`.
- R7: A watchdog step happens when a watchdog period ends, with E = WD_BASE_EXP + EXP_STEP*ctrl[31:30] under the same rule as R6. If status bit 31 is clear, the step sets it.
- R8: If bit 31 is set and bit 30 is clear, a step sets bit 30 and raises `irq_wdt` when the watchdog interrupt enable is set. Writing 1 to status bit 30 drops `irq_wdt`.
- R9: If bits 31 and 30 are both set, a step copies the reset-kind field into status [29:28]. Kind 1 gives a one-cycle `rst_core_req` pulse, kind 2 a `rst_chip_req` pulse, kind 3 a `rst_sys_req` pulse, and kind 0 gives no pulse.
- R10: A status bit or interrupt request that an event sets in the same cycle as a write-one-to-clear of that bit ends up set.
- R11: Every control write counts as exactly one watchdog step, even when a period ends in the same cycle. That step uses the newly written enable and reset-kind fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Shared time-base tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 interval reload, 3 none |
| wr_data | input | 32 | Write data |
| ctrl_o | output | 32 | Current control word |
| stat_o | output | 32 | Current status word |
| pit_cnt_o | output | PIT_W | Current interval count |
| irq_pit | output | 1 | Interval timer interrupt request |
| irq_fit | output | 1 | Fixed interval interrupt request |
| irq_wdt | output | 1 | Watchdog interrupt request |
| rst_core_req | output | 1 | Core reset request pulse |
| rst_chip_req | output | 1 | Chip reset request pulse |
| rst_sys_req | output | 1 | System reset request pulse |

## Verification
The assertions in the design check, on every cycle, the properties that hold for each step on its own:
- at most one reset pulse is active at a time;
- a reset pulse only follows a cycle in which both watchdog stages were already set;
- the watchdog interrupt stage never rises before the enable stage;
- an idle interval count holds, and an expiry either reloads the count or parks it at zero;
- a fixed-timer period end always leaves its status bit set.

Other behaviour depends on sequences and timing that only the bench's scenarios can show:
- the period lengths chosen by each select field;
- the full three-step watchdog sequence driven by control writes and by elapsed periods;
- the odd rule that clearing status bit 31 also drops the interval interrupt;
- a clear that lands in the same cycle as a fixed-timer period end.

For those, a cycle model in the bench is compared with the ports on every cycle, alongside directed corner cases.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;
   typedef enum logic [1:0] {
      WSEL_CTRL = 2'd0,
      WSEL_STAT = 2'd1,
      WSEL_PIT  = 2'd2,
      WSEL_NONE = 2'd3
   } wsel_e;

   localparam logic [31:0] CTRL_KEEP = 32'hFFC0_0000;
   localparam logic [31:0] STAT_W1C  = 32'hFC00_0000;

   // control field positions
   localparam int C_WD_PER  = 30;
   localparam int C_WD_KIND = 28;
   localparam int C_WD_IE   = 27;
   localparam int C_PIT_IE  = 26;
   localparam int C_FIT_PER = 24;
   localparam int C_FIT_IE  = 23;
   localparam int C_PIT_ARE = 22;

   // status field positions
   localparam int S_WD_EN   = 31;
   localparam int S_WD_INT  = 30;
   localparam int S_PIT     = 27;
   localparam int S_FIT     = 26;
endpackage

// File: rtl/emb_tmr_period.sv
module emb_tmr_period #(
   parameter int BASE_EXP = 9,
   parameter int EXP_STEP = 4,
   localparam int TOP_EXP = BASE_EXP + 3 * EXP_STEP
) (
   input  logic               tick,
   input  logic [TOP_EXP-1:0] tb,
   input  logic [1:0]         sel,
   output logic               evt
);
   logic [3:0] hit;

   for (genvar g = 0; g < 4; g++) begin : g_tap
      localparam int E = BASE_EXP + g * EXP_STEP;
      assign hit[g] = &tb[E-1:0];
   end

   assign evt = tick & hit[sel];
endmodule

// File: rtl/emb_tmr_pit.sv
module emb_tmr_pit #(
   parameter int PIT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [PIT_W-1:0] ld_val,
   input  logic             ie,
   input  logic             are,
   output logic [PIT_W-1:0] cnt,
   output logic             expire
);
   localparam logic [PIT_W-1:0] ONE = {{(PIT_W-1){1'b0}}, 1'b1};

   logic [PIT_W-1:0] cnt_q, rel_q;
   logic             running;

   assign running = (rel_q > ONE) && ie && (cnt_q != '0);
   assign expire  = tick && running && (cnt_q == ONE) && !ld;
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
         rel_q <= ld_val;
      end else if (tick && running) begin
         if (cnt_q == ONE) cnt_q <= are ? rel_q : '0;
         else              cnt_q <= cnt_q - ONE;
      end
   end

   AST_PIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !(tick && running)) |=> $stable(cnt_q)); // R4
   AST_PIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && are) |=> (cnt_q == $past(rel_q))); // R5
   AST_PIT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !are) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/emb_tmr_wdog.sv
module emb_tmr_wdog (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       ie,
   input  logic [1:0] kind,
   input  logic [3:0] clr,
   output logic [3:0] st,
   output logic       irq,
   output logic [2:0] rst_pulse
);
   logic [3:0] st_q, st_n;
   logic       irq_q, irq_n;
   logic [2:0] rp_q, rp_n;

   always_comb begin
      st_n  = st_q & ~clr;
      irq_n = irq_q & ~clr[2];
      rp_n  = '0;
      if (step) begin
         if (!st_q[3]) begin
            st_n[3] = 1'b1;
         end else if (!st_q[2]) begin
            st_n[2] = 1'b1;
            if (ie) irq_n = 1'b1;
         end else begin
            st_n[1:0] = kind;
            case (kind)
               2'd1:    rp_n = 3'b001;
               2'd2:    rp_n = 3'b010;
               2'd3:    rp_n = 3'b100;
               default: rp_n = 3'b000;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         irq_q <= 1'b0;
         rp_q  <= '0;
      end else begin
         st_q  <= st_n;
         irq_q <= irq_n;
         rp_q  <= rp_n;
      end
   end

   assign st        = st_q;
   assign irq       = irq_q;
   assign rst_pulse = rp_q;

   AST_WD_ONE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rp_q)); // R9
   AST_WD_RESET_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (|rp_q) |-> $past(st_q[3] & st_q[2])); // R9
   AST_WD_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|rp_q) |-> (st_q[1:0] != 2'd0)); // R9
   AST_WD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[2]) |-> $past(st_q[3])); // R8
endmodule

// File: rtl/emb_tmr_top.sv
module emb_tmr_top
   import emb_tmr_pkg::*;
#(
   parameter int PIT_W        = 32,
   parameter int FIT_BASE_EXP = 9,
   parameter int WD_BASE_EXP  = 17,
   parameter int EXP_STEP     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [31:0]      wr_data,
   output logic [31:0]      ctrl_o,
   output logic [31:0]      stat_o,
   output logic [PIT_W-1:0] pit_cnt_o,
   output logic             irq_pit,
   output logic             irq_fit,
   output logic             irq_wdt,
   output logic             rst_core_req,
   output logic             rst_chip_req,
   output logic             rst_sys_req
);
   localparam int FIT_TOP = FIT_BASE_EXP + 3 * EXP_STEP;
   localparam int WD_TOP  = WD_BASE_EXP + 3 * EXP_STEP;
   localparam int TB_W    = (FIT_TOP > WD_TOP) ? FIT_TOP : WD_TOP;

   if (PIT_W < 2 || PIT_W > 32) begin : g_bad_pit_w
      $error("PIT_W must lie in 2..32");
   end
   if (FIT_BASE_EXP < 1 || WD_BASE_EXP < 1 || EXP_STEP < 0) begin : g_bad_exp
      $error("period exponents must be positive");
   end
   if (TB_W > 63) begin : g_bad_tb_w
      $error("time base wider than 63 bits");
   end

   logic            wr_ctrl, wr_stat, wr_pit;
   logic [31:22]    ctrl_q;
   logic [31:26]    stat_clr;
   logic [TB_W-1:0] tb_q;
   logic            fit_evt, wd_evt, pit_exp;
   logic            pit_st_q, fit_st_q, pit_irq_q, fit_irq_q;
   logic [3:0]      wd_st;
   logic [2:0]      wd_rp;
   logic            wd_ie_eff;
   logic [1:0]      wd_kind_eff;

   assign wr_ctrl  = wr_en && (wr_sel == WSEL_CTRL);
   assign wr_stat  = wr_en && (wr_sel == WSEL_STAT);
   assign wr_pit   = wr_en && (wr_sel == WSEL_PIT);
   assign stat_clr = wr_stat ? (wr_data[31:26] & STAT_W1C[31:26]) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tb_q <= '0;
      else if (tick) tb_q <= tb_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wr_data[31:22] & CTRL_KEEP[31:22];
   end

   emb_tmr_period #(.BASE_EXP(FIT_BASE_EXP), .EXP_STEP(EXP_STEP)) u_fit_per (
      .tick (tick),
      .tb   (tb_q[FIT_TOP-1:0]),
      .sel  (ctrl_q[C_FIT_PER+1:C_FIT_PER]),
      .evt  (fit_evt)
   );

   emb_tmr_period #(.BASE_EXP(WD_BASE_EXP), .EXP_STEP(EXP_STEP)) u_wd_per (
      .tick (tick),
      .tb   (tb_q[WD_TOP-1:0]),
      .sel  (ctrl_q[C_WD_PER+1:C_WD_PER]),
      .evt  (wd_evt)
   );

   emb_tmr_pit #(.PIT_W(PIT_W)) u_pit (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .ld     (wr_pit),
      .ld_val (wr_data[PIT_W-1:0]),
      .ie     (ctrl_q[C_PIT_IE]),
      .are    (ctrl_q[C_PIT_ARE]),
      .cnt    (pit_cnt_o),
      .expire (pit_exp)
   );

   assign wd_ie_eff   = wr_ctrl ? wr_data[C_WD_IE] : ctrl_q[C_WD_IE];
   assign wd_kind_eff = wr_ctrl ? wr_data[C_WD_KIND+1:C_WD_KIND]
                                : ctrl_q[C_WD_KIND+1:C_WD_KIND];

   emb_tmr_wdog u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (wd_evt | wr_ctrl),
      .ie        (wd_ie_eff),
      .kind      (wd_kind_eff),
      .clr       (stat_clr[31:28]),
      .st        (wd_st),
      .irq       (irq_wdt),
      .rst_pulse (wd_rp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pit_st_q  <= 1'b0;
         fit_st_q  <= 1'b0;
         pit_irq_q <= 1'b0;
         fit_irq_q <= 1'b0;
      end else begin
         pit_st_q  <= (pit_st_q & ~stat_clr[S_PIT]) | pit_exp;
         fit_st_q  <= (fit_st_q & ~stat_clr[S_FIT]) | fit_evt;
         pit_irq_q <= (pit_irq_q & ~stat_clr[S_WD_EN]) | (pit_exp & ctrl_q[C_PIT_IE]);
         fit_irq_q <= (fit_irq_q & ~stat_clr[S_FIT]) | (fit_evt & ctrl_q[C_FIT_IE]);
      end
   end

   assign ctrl_o       = {ctrl_q, 22'b0};
   assign stat_o       = {wd_st, pit_st_q, fit_st_q, 26'b0};
   assign irq_pit      = pit_irq_q;
   assign irq_fit      = fit_irq_q;
   assign rst_core_req = wd_rp[0];
   assign rst_chip_req = wd_rp[1];
   assign rst_sys_req  = wd_rp[2];

   AST_FIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      fit_evt |=> stat_o[S_FIT]); // R10
   AST_PIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      pit_exp |=> (stat_o[S_PIT] && irq_pit)); // R5
   AST_PIT_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wr_data[S_WD_EN] && !pit_exp) |=> !irq_pit); // R3
   AST_WDT_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wr_data[S_WD_INT] && !wr_ctrl && !wd_evt) |=> !irq_wdt); // R8
endmodule

// File: tb/tb_emb_tmr_top.sv
module tb_emb_tmr_top;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 16;
   localparam int FB = 3;
   localparam int WB = 5;
   localparam int ST = 1;

   logic          clk, rst_n, tick, wr_en;
   logic [1:0]    wr_sel;
   logic [31:0]   wr_data;
   logic [31:0]   ctrl_o, stat_o;
   logic [PW-1:0] pit_cnt_o;
   logic          irq_pit, irq_fit, irq_wdt;
   logic          rst_core_req, rst_chip_req, rst_sys_req;

   int checks = 0;
   int errors = 0;
   logic cmp_on = 1'b0;

   emb_tmr_top #(.PIT_W(PW), .FIT_BASE_EXP(FB), .WD_BASE_EXP(WB), .EXP_STEP(ST)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ctrl_o(ctrl_o), .stat_o(stat_o), .pit_cnt_o(pit_cnt_o),
      .irq_pit(irq_pit), .irq_fit(irq_fit), .irq_wdt(irq_wdt),
      .rst_core_req(rst_core_req), .rst_chip_req(rst_chip_req), .rst_sys_req(rst_sys_req)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   logic [31:0]   m_tb, m_ctrl, m_stat;
   logic [PW-1:0] m_rel, m_cnt;
   logic          m_pirq, m_firq, m_wirq;
   logic [2:0]    m_rst;

   function automatic logic [31:0] pmask(int base, logic [1:0] sel);
      return (32'd1 << (base + int'(sel) * ST)) - 32'd1;
   endfunction

   always @(posedge clk) begin : model
      logic fe, we, run, pexp, wctl, wst, wpit, np, nf, nw;
      logic [31:0] clr, ns, cv;
      logic [PW-1:0] nc;
      logic [2:0] nr;
      if (!rst_n) begin
         m_tb <= '0; m_ctrl <= '0; m_stat <= '0; m_rel <= '0; m_cnt <= '0;
         m_pirq <= 1'b0; m_firq <= 1'b0; m_wirq <= 1'b0; m_rst <= '0;
      end else begin
         wctl = wr_en && (wr_sel == 2'd0);
         wst  = wr_en && (wr_sel == 2'd1);
         wpit = wr_en && (wr_sel == 2'd2);
         fe = tick && ((m_tb & pmask(FB, m_ctrl[25:24])) == pmask(FB, m_ctrl[25:24]));
         we = tick && ((m_tb & pmask(WB, m_ctrl[31:30])) == pmask(WB, m_ctrl[31:30]));
         run  = (m_rel > 1) && m_ctrl[26] && (m_cnt != 0);
         pexp = tick && run && (m_cnt == 1) && !wpit;
         if (wpit) nc = wr_data[PW-1:0];
         else if (tick && run) nc = (m_cnt == 1) ? (m_ctrl[22] ? m_rel : '0) : m_cnt - 1'b1;
         else nc = m_cnt;
         clr = wst ? (wr_data & 32'hFC00_0000) : 32'h0;
         ns = m_stat & ~clr;
         np = m_pirq & ~clr[31];
         nf = m_firq & ~clr[26];
         nw = m_wirq & ~clr[30];
         nr = 3'b000;
         if (pexp) begin ns[27] = 1'b1; if (m_ctrl[26]) np = 1'b1; end
         if (fe) begin ns[26] = 1'b1; if (m_ctrl[23]) nf = 1'b1; end
         cv = wctl ? wr_data : m_ctrl;
         if (we || wctl) begin
            if (!m_stat[31]) ns[31] = 1'b1;
            else if (!m_stat[30]) begin ns[30] = 1'b1; if (cv[27]) nw = 1'b1; end
            else begin
               ns[29:28] = cv[29:28];
               if (cv[29:28] == 2'd1) nr = 3'b001;
               if (cv[29:28] == 2'd2) nr = 3'b010;
               if (cv[29:28] == 2'd3) nr = 3'b100;
            end
         end
         m_tb   <= tick ? m_tb + 1 : m_tb;
         m_ctrl <= wctl ? (wr_data & 32'hFFC0_0000) : m_ctrl;
         m_stat <= ns;
         if (wpit) m_rel <= wr_data[PW-1:0];
         m_cnt  <= nc;
         m_pirq <= np; m_firq <= nf; m_wirq <= nw; m_rst <= nr;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R2 model ctrl", ctrl_o, m_ctrl);
         chk("R3 R7 R10 model stat", stat_o, m_stat);
         chk("R4 model count", 32'(pit_cnt_o), 32'(m_cnt));
         chk("R5 model irq_pit", 32'(irq_pit), 32'(m_pirq));
         chk("R6 model irq_fit", 32'(irq_fit), 32'(m_firq));
         chk("R8 model irq_wdt", 32'(irq_wdt), 32'(m_wirq));
         chk("R9 model resets", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, {29'b0, m_rst});
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wr_sel = 2'd3;
   endtask

   task automatic run_ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] snap;
      int unsigned seed;
      seed = $urandom(32'd4242);
      rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ctrl", ctrl_o, 32'h0);
      chk("R1 stat", stat_o, 32'h0);
      chk("R1 count", 32'(pit_cnt_o), 32'h0);
      chk("R1 irqs", {29'b0, irq_pit, irq_fit, irq_wdt}, 32'h0);
      chk("R1 resets", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;

      // R2 masking and ignored select
      wr(2'd0, 32'hFFFF_FFFF);
      chk("R2 masked ctrl", ctrl_o, 32'hFFC0_0000);
      snap = stat_o;
      wr(2'd3, 32'h1234_5678);
      chk("R2 select 3 ctrl", ctrl_o, 32'hFFC0_0000);
      chk("R2 select 3 stat", stat_o, snap);
      wr(2'd1, 32'hFFFF_FFFF);
      chk("R3 clear all", stat_o, 32'h0);

      // R4 R5 interval timer
      wr(2'd0, 32'h0440_0000);
      wr(2'd2, 32'd1);
      run_ticks(4);
      chk("R4 reload 1 holds", 32'(pit_cnt_o), 32'd1);
      wr(2'd2, 32'd3);
      chk("R4 load", 32'(pit_cnt_o), 32'd3);
      run_ticks(2);
      chk("R4 decrement", 32'(pit_cnt_o), 32'd1);
      run_ticks(1);
      chk("R5 auto reload", 32'(pit_cnt_o), 32'd3);
      chk("R5 status 27", 32'(stat_o[27]), 32'd1);
      chk("R5 irq_pit", 32'(irq_pit), 32'd1);
      wr(2'd1, 32'h8000_0000);
      chk("R3 bit31 drops irq_pit", 32'(irq_pit), 32'd0);
      chk("R3 bit27 kept", 32'(stat_o[27]), 32'd1);
      wr(2'd0, 32'h0400_0000);
      wr(2'd2, 32'd2);
      run_ticks(2);
      chk("R5 no reload parks", 32'(pit_cnt_o), 32'd0);
      run_ticks(3);
      chk("R5 parked stays", 32'(pit_cnt_o), 32'd0);
      wr(2'd0, 32'h0000_0000);
      wr(2'd2, 32'd5);
      run_ticks(3);
      chk("R4 enable clear holds", 32'(pit_cnt_o), 32'd5);

      // R6 fixed timer
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0080_0000);
      run_ticks(8);
      chk("R6 status 26", 32'(stat_o[26]), 32'd1);
      chk("R6 irq_fit", 32'(irq_fit), 32'd1);
      wr(2'd1, 32'h0400_0000);
      chk("R6 clear status", 32'(stat_o[26]), 32'd0);
      chk("R6 clear irq", 32'(irq_fit), 32'd0);

      // R10 clear in the cycle of a period end
      tick = 1'b1;
      while (m_tb[2:0] != 3'd7) @(negedge clk);
      wr(2'd1, 32'h0400_0000);
      tick = 1'b0;
      chk("R10 set beats clear", 32'(stat_o[26]), 32'd1);
      chk("R10 irq set beats clear", 32'(irq_fit), 32'd1);

      // R7 R8 R9 R11 watchdog through control writes
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h2800_0000);
      chk("R11 write steps stage 1", stat_o, 32'h8000_0000);
      wr(2'd0, 32'h2800_0000);
      chk("R8 stage 2", stat_o, 32'hC000_0000);
      chk("R8 irq_wdt", 32'(irq_wdt), 32'd1);
      wr(2'd0, 32'h2800_0000);
      chk("R9 stage 3 kind", stat_o, 32'hE000_0000);
      chk("R9 chip pulse", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b010);
      @(negedge clk);
      chk("R9 pulse one cycle", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b000);
      wr(2'd1, 32'hC000_0000);
      chk("R3 partial clear", stat_o, 32'h2000_0000);
      chk("R8 irq drop", 32'(irq_wdt), 32'd0);

      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h0000_0000);
      chk("R11 step with new enable", stat_o, 32'h8000_0000);
      run_ticks(32);
      chk("R7 period step", {28'b0, stat_o[31:28]}, 32'hC);
      chk("R8 disabled no irq", 32'(irq_wdt), 32'd0);
      wr(2'd0, 32'h0000_0000);
      chk("R9 kind 0 status", {28'b0, stat_o[31:28]}, 32'hC);
      chk("R9 kind 0 no pulse", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b000);
      wr(2'd0, 32'h3000_0000);
      chk("R9 system pulse", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b100);
      wr(2'd0, 32'h1000_0000);
      chk("R9 core pulse", {29'b0, rst_sys_req, rst_chip_req, rst_core_req}, 32'b001);
      chk("R9 core kind", {30'b0, stat_o[29:28]}, 32'd1);

      // random traffic checked against the model every cycle
      for (int i = 0; i < 20000; i++) begin
         tick = ($urandom % 4) != 0;
         if (($urandom % 12) == 0) begin
            wr_en = 1'b1;
            wr_sel = 2'($urandom % 4);
            wr_data = (wr_sel == 2'd2) ? ($urandom % 40) : $urandom;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0; tick = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule